// File: doc/BRIEF.md
# Four-Bank Interleaved Block Refill Controller

This block answers cache block refill requests from four banks, each one word wide. A request carries a block address. The controller latches that address, holds it for the whole refill, and returns the four words of the block. Word k of every block lives in bank k, so the offset of a word inside its block selects its bank. The banks are modelled inside the block as plain arrays. The access latency is modelled by a cycle counter, not by real device timing.

A build-time parameter selects one of three memory organizations, so that their miss penalties can be compared on identical traffic:

- **One-word-wide memory.** Every word pays its own access start and its own transfer.
- **Four-word-wide memory.** The whole block moves in a single transfer.
- **Four-bank interleaved memory.** One address reaches all four banks, the banks are read together, and the words are then streamed out one per cycle.

The three timing components are parameters: address send takes 1 cycle, an access start takes 15 cycles and a word transfer takes 1 cycle. With these defaults the penalties are 65, 17 and 20 cycles.

A simple single-cycle block write path fills the banks. It writes all four words of one block in one cycle.

Top module: `interleaved_refill_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `out_mask` is 0 and `done` is 0.
- R2: A request is accepted on a rising edge where `req` and `ready` are both 1. Cycle 1 is the first cycle after the accepting edge. `ready` is 0 from cycle 1 through cycle P, where P is the penalty of the selected organization, and is 1 again from cycle P+1.
- R3: A `req` raised while `ready` is 0 is ignored. The block in flight keeps its address and its timing.
- R4: With ORG=2 (interleaved), P is 20. Word k is flagged alone, on `out_mask` bit k, in cycle 17+k. Lane k (`out_data` bits 32k+31:32k) then carries bank k's word of the requested block.
- R5: With ORG=0 (one word wide), P is 65. Word k is flagged alone, on `out_mask` bit k, in cycle 17+16k, with the same lane placement as R4.
- R6: With ORG=1 (four words wide), P is 17. All four mask bits are set together in cycle 17 only, and all four lanes carry the block.
- R7: `done` is a one-cycle pulse in cycle P+1, and `ready` is 1 in that same cycle.
- R8: A write (`wr_en` high on an edge while `ready` is 1) stores lane k of `wr_data` into bank k at `wr_addr`. A write while `ready` is 0 has no effect.
- R9: Outside the strobe cycles `out_mask` is 0. Any lane whose mask bit is 0 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Refill request |
| req_addr | input | ADDR_W | Block address of the refill |
| ready | output | 1 | High when a request can be taken |
| wr_en | input | 1 | Block write strobe |
| wr_addr | input | ADDR_W | Block address to write |
| wr_data | input | NBANK*DATA_W | Block to write; lane k goes to bank k |
| out_mask | output | NBANK | Per-lane valid flags for returned words |
| out_data | output | NBANK*DATA_W | Returned words, one lane per bank |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
Every result is tied to a cycle count taken from the accepting edge.

- **Word strobes.** Word k is due in cycle 17+k (interleaved), 17+16k (one-word-wide) or 17 (wide).
- **Handshake.** `ready` stays low through cycle P. `done` and the return of `ready` land in cycle P+1.

The bench runs all three organizations side by side on the same stimulus. It checks every output at the falling edge of each numbered cycle, from cycle 1 to cycle 67, against a strobe schedule computed arithmetically. One run injects a request and a write in cycle 4, while all three instances are busy. That run then confirms the refill timing and the stored data are both unchanged.

// File: rtl/interleaved_refill_ctrl.sv
module interleaved_refill_ctrl #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int NBANK      = 4,
  parameter int ORG        = 2,
  parameter int ADDR_CYC   = 1,
  parameter int ACCESS_CYC = 15,
  parameter int XFER_CYC   = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    ready,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [NBANK*DATA_W-1:0] wr_data,
  output logic [NBANK-1:0]        out_mask,
  output logic [NBANK*DATA_W-1:0] out_data,
  output logic                    done
);

  function automatic int strobe_at(input int k);
    if (ORG == 0)      return ADDR_CYC + (k + 1) * (ACCESS_CYC + XFER_CYC);
    else if (ORG == 1) return ADDR_CYC + ACCESS_CYC + XFER_CYC;
    else               return ADDR_CYC + ACCESS_CYC + (k + 1) * XFER_CYC;
  endfunction

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PENALTY = strobe_at(NBANK - 1);
  localparam int CW      = $clog2(PENALTY + 2);

  logic              busy;
  logic              done_q;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] cur;

  wire accept  = req && !busy;
  wire last    = busy && (cnt == CW'(PENALTY));
  wire wr_take = wr_en && !busy;

  assign ready = !busy;
  assign done  = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      cur    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= CW'(1);
        cur  <= req_addr;
      end else if (last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int T = strobe_at(b);
    logic [DATA_W-1:0] mem [DEPTH];
    wire hit = busy && (cnt == CW'(T));

    always_ff @(posedge clk) begin
      if (wr_take) mem[wr_addr] <= wr_data[b*DATA_W +: DATA_W];
    end

    assign out_mask[b]                   = hit;
    assign out_data[b*DATA_W +: DATA_W]  = hit ? mem[cur] : '0;
  end

  p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready) |=> !ready);

  p_quiet_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (out_mask == '0));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_with_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

  p_one_word_per_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ORG == 1) || $onehot0(out_mask));

  p_busy_ignores_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !last) |=> (!ready && $stable(cur)));

endmodule

// File: tb/interleaved_refill_ctrl_test.sv
module interleaved_refill_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [NB*DW-1:0] wr_data = '0;

  logic           rdy [3];
  logic           dn  [3];
  logic [NB-1:0]  msk [3];
  logic [NB*DW-1:0] dat [3];

  logic [NB*DW-1:0] exp_mem [1<<AW];
  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interleaved_refill_ctrl #(.ORG(2)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .ready(rdy[2]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_mask(msk[2]), .out_data(dat[2]), .done(dn[2]));

  interleaved_refill_ctrl #(.ORG(0)) uut_one (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .ready(rdy[0]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_mask(msk[0]), .out_data(dat[0]), .done(dn[0]));

  interleaved_refill_ctrl #(.ORG(1)) uut_wide (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .ready(rdy[1]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_mask(msk[1]), .out_data(dat[1]), .done(dn[1]));

  function automatic int strobe_t(input int o, input int k);
    if (o == 0)      return 1 + (k + 1) * 16;
    else if (o == 1) return 17;
    else             return 16 + (k + 1);
  endfunction

  function automatic logic [NB*DW-1:0] pat(input int a, input int salt);
    logic [NB*DW-1:0] v;
    for (int k = 0; k < NB; k++)
      v[k*DW +: DW] = 32'((a * 4 + k) * 40503 + salt * 7919) ^ 32'h5A5A_0000;
    return v;
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [NB*DW-1:0] act,
                     input logic [NB*DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic write_blk(input int a, input logic [NB*DW-1:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = v;
    exp_mem[a] = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_read(input int a, input bit disturb, input string dtag);
    @(negedge clk);
    for (int o = 0; o < 3; o++) chk(rdy[o] === 1'b1, "R2", {127'b0, rdy[o]}, 1);
    req = 1'b1; req_addr = AW'(a);
    for (int c = 1; c <= 67; c++) begin
      @(negedge clk);
      if (c == 1) req = 1'b0;
      for (int o = 0; o < 3; o++) begin
        logic [NB-1:0] em;
        logic [NB*DW-1:0] ed;
        string tg;
        int p;
        p = strobe_t(o, NB - 1);
        em = '0; ed = '0;
        for (int k = 0; k < NB; k++)
          if (c == strobe_t(o, k)) begin
            em[k] = 1'b1;
            ed[k*DW +: DW] = exp_mem[a][k*DW +: DW];
          end
        tg = (o == 0) ? "R5" : (o == 1) ? "R6" : "R4";
        if (em == '0) tg = "R9";
        if (dtag != "") tg = dtag;
        chk(msk[o] === em, tg, {124'b0, msk[o]}, {124'b0, em});
        chk(dat[o] === ed, tg, dat[o], ed);
        chk(rdy[o] === (c > p), "R2", {127'b0, rdy[o]}, {127'b0, (c > p)});
        chk(dn[o] === (c == p + 1), "R7", {127'b0, dn[o]}, {127'b0, (c == p + 1)});
      end
      if (disturb && c == 4) begin
        req = 1'b1; req_addr = AW'(a ^ 63);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = {NB*DW{1'b1}};
      end
      if (disturb && c == 5) begin
        req = 1'b0; wr_en = 1'b0;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    for (int o = 0; o < 3; o++) begin
      chk(rdy[o] === 1'b1, "R1", {127'b0, rdy[o]}, 1);
      chk(msk[o] === '0, "R1", {124'b0, msk[o]}, 0);
      chk(dn[o] === 1'b0, "R1", {127'b0, dn[o]}, 0);
    end

    for (int a = 0; a < (1 << AW); a++) write_blk(a, pat(a, 1));

    for (int a = 0; a < (1 << AW); a += 5) run_read(a, 1'b0, "");
    run_read(63, 1'b0, "");

    run_read(9, 1'b1, "R3");
    run_read(9, 1'b0, "R8");

    write_blk(63, pat(63, 2));
    write_blk(0, pat(0, 3));
    run_read(63, 1'b0, "R8");
    run_read(0, 1'b0, "R8");

    finish_run();
  end
endmodule